// File: doc/BRIEF.md
# Dual-Source System Clock Generator

This block produces the internal system clock from a fast main oscillator and a slow sub-oscillator. A two-bit speed selector picks one of three ratios: main clock divided by 8 (the default after reset), main clock divided by 2, or sub-clock divided by 2. All sequential logic runs on the main clock. The sub-clock is sampled through a synchronizer, so the main clock must run at more than three times the sub-clock frequency. The system clock is a registered output and carries no combinational glitches.

Two halt requests are accepted. A wait request parks the system clock high and leaves both oscillator enables unchanged. A stop request parks the clock high and drops both oscillator enables. Either halt ends on reset, or when an interrupt line is raised while its enable bit is set. In low-speed mode, software may turn the main oscillator off. The sub-oscillator starts disabled, and its pins are held at high impedance until software enables it.

Top module: `sysclk_gen`

## Requirements
- R1: While `rst_n` is low, `sys_clk`=1, `main_osc_en`=1, `sub_osc_en`=0 and `sub_osc_hiz`=1. With `speed_sel`=01, the first falling edge of `sys_clk` comes 6 main-clock cycles after `rst_n` rises: 2 cycles of reset release plus a 4-cycle high phase.
- R2: `speed_sel`=01 (middle ratio) or 11 gives a `sys_clk` period of 8 main cycles, high for 4 and low for 4.
- R3: `speed_sel`=00 (high ratio) gives a `sys_clk` period of 2 main cycles.
- R4: `speed_sel`=10 (low ratio) toggles `sys_clk` on every synchronized rising edge of `sub_osc_in`, so the period is twice the sub-clock period.
- R5: A new ratio takes over only at the end of a high phase. That high phase is lengthened by one half-period of the new ratio, so a change between the middle ratio and the high ratio gives a single high phase of 5 main cycles.
- R6: When `main_osc_off`=1 and the active ratio is low-speed, `main_osc_en` goes to 0. With any other active ratio, `main_osc_off` has no effect and `main_osc_en` stays 1.
- R7: `sub_osc_en` follows `sub_osc_on` one cycle later, and `sub_osc_hiz` is its inverse.
- R8: After a `wait_req` pulse, `sys_clk` parks high at the end of its current high phase. `main_osc_en` and `sub_osc_en` hold their values for the whole halt.
- R9: A halt ends when some bit of `irq_req` is set together with the same bit of `irq_en`. Clocking then resumes with a full high half-period.
- R10: During a halt, an `irq_req` bit whose `irq_en` bit is clear does not wake the block, and `sys_clk` stays high.
- R11: After a `stop_req` pulse, `sys_clk` parks high and both oscillator enables go to 0. On wake, both enables return to the values that the controls select.
- R12: When `stop_req` and `wait_req` are raised in the same cycle, the stop request wins.
- R13: A reset during a halt returns the block to running at the middle ratio, with `main_osc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_osc_in | input | 1 | Sub-oscillator clock, sampled |
| speed_sel | input | 2 | Ratio select: 00 high, 01 middle, 10 low, 11 middle |
| main_osc_off | input | 1 | Request to switch the main oscillator off in low-speed mode |
| sub_osc_on | input | 1 | Enable for the sub-oscillator |
| wait_req | input | 1 | One-cycle wait strobe |
| stop_req | input | 1 | One-cycle stop strobe |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line wake enables |
| sys_clk | output | 1 | Divided system clock |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub-oscillator enable |
| sub_osc_hiz | output | 1 | Sub-oscillator pins to high impedance |

## Verification
Each result has a fixed latency. Oscillator enables follow a control change one main cycle later. The first `sys_clk` fall after reset comes six cycles after release. A wake takes two cycles to pass through the halt state and the divider, and a ratio change waits for the end of the current high phase. The bench drives inputs and samples outputs on the falling main-clock edge. It measures periods and high-phase lengths between observed `sys_clk` edges instead of at fixed instants, and before any level check it allows a settling window longer than the worst-case phase end.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10
  } speed_e;

  typedef enum logic [2:0] {
    PS_RUN,
    PS_PARK_W,
    PS_PARK_S,
    PS_HALT_W,
    PS_HALT_S
  } pwr_state_e;

  // 11 is folded onto the middle ratio
  function automatic speed_e speed_decode(input logic [1:0] raw);
    case (raw)
      2'b00:   return SPD_HIGH;
      2'b10:   return SPD_LOW;
      default: return SPD_MID;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_sub_sync.sv
module clkgen_sub_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
  import clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  input  logic wake,
  input  logic parked,
  output logic hold_req,
  output logic in_wait,
  output logic in_stop
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_RUN: begin
        if (stop_req)      state_d = PS_PARK_S;
        else if (wait_req) state_d = PS_PARK_W;
      end
      PS_PARK_W: if (parked) state_d = PS_HALT_W;
      PS_PARK_S: if (parked) state_d = PS_HALT_S;
      PS_HALT_W: if (wake)   state_d = PS_RUN;
      PS_HALT_S: if (wake)   state_d = PS_RUN;
      default:               state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  assign hold_req = (state_q != PS_RUN);
  assign in_wait  = (state_q == PS_HALT_W);
  assign in_stop  = (state_q == PS_HALT_S);
endmodule

// File: rtl/clkgen_osc_ctl.sv
module clkgen_osc_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic main_off,
  input  logic sub_on,
  input  logic act_low,
  input  logic in_wait,
  input  logic in_stop,
  output logic main_en,
  output logic sub_en
);
  logic main_q, main_d, sub_q, sub_d, upd;

  always_comb begin
    upd = ~in_wait;
    if (in_stop) begin
      main_d = 1'b0;
      sub_d  = 1'b0;
    end else begin
      main_d = ~(main_off & act_low);
      sub_d  = sub_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= 1'b1;
      sub_q  <= 1'b0;
    end else if (upd) begin
      main_q <= main_d;
      sub_q  <= sub_d;
    end
  end

  assign main_en = main_q;
  assign sub_en  = sub_q;
endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
  import clkgen_pkg::*;
#(
  parameter int MID_DIV  = 8,
  parameter int HIGH_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  speed_e req_mode,
  input  logic   sub_rise,
  input  logic   hold_req,
  output logic   sys_clk,
  output logic   parked,
  output speed_e act_mode
);
  localparam int MID_HALF  = MID_DIV / 2;
  localparam int HIGH_HALF = HIGH_DIV / 2;
  localparam int CNT_W     = (MID_HALF > 1) ? $clog2(MID_HALF) : 1;
  localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(MID_HALF - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_last;
  logic             clk_q, clk_d, park_q, park_d, armed_q, armed_d, tick;
  speed_e           mode_q, mode_d;

  always_comb begin
    cnt_d     = cnt_q;
    clk_d     = clk_q;
    park_d    = park_q;
    armed_d   = armed_q;
    mode_d    = mode_q;
    half_last = (mode_q == SPD_MID) ? MID_LAST : HIGH_LAST;
    tick      = (mode_q == SPD_LOW) ? (sub_rise & armed_q) : (cnt_q == half_last);
    if (park_q) begin
      if (!hold_req) begin
        park_d  = 1'b0;
        cnt_d   = '0;
        armed_d = 1'b0;
      end
    end else begin
      if (mode_q == SPD_LOW) begin
        cnt_d = '0;
        if (sub_rise) armed_d = 1'b1;
      end else begin
        cnt_d = tick ? '0 : cnt_q + 1'b1;
      end
      if (tick) begin
        if (!clk_q) begin
          clk_d = 1'b1;
        end else if (hold_req) begin
          park_d  = 1'b1;
          armed_d = 1'b0;
        end else if (req_mode != mode_q) begin
          mode_d  = req_mode;
          cnt_d   = '0;
          armed_d = 1'b0;
        end else begin
          clk_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clk_q   <= 1'b1;
      park_q  <= 1'b0;
      armed_q <= 1'b0;
      mode_q  <= SPD_MID;
    end else begin
      cnt_q   <= cnt_d;
      clk_q   <= clk_d;
      park_q  <= park_d;
      armed_q <= armed_d;
      mode_q  <= mode_d;
    end
  end

  assign sys_clk  = clk_q;
  assign parked   = park_q;
  assign act_mode = mode_q;
endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen
  import clkgen_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int MID_DIV     = 8,
  parameter int HIGH_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_main,
  input  logic             rst_n,
  input  logic             sub_osc_in,
  input  logic [1:0]       speed_sel,
  input  logic             main_osc_off,
  input  logic             sub_osc_on,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             sys_clk,
  output logic             main_osc_en,
  output logic             sub_osc_en,
  output logic             sub_osc_hiz
);
  logic [1:0]       rst_pipe;
  logic             rst_int, sub_rise, wake, parked, hold_req, in_wait, in_stop;
  logic [N_IRQ-1:0] irq_hit;
  speed_e           act_mode;

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign irq_hit[i] = irq_req[i] & irq_en[i];
  end
  assign wake = |irq_hit;

  clkgen_sub_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_main), .rst_n(rst_int), .din(sub_osc_in), .rise(sub_rise)
  );

  clkgen_pwr_seq u_seq (
    .clk(clk_main), .rst_n(rst_int), .wait_req(wait_req), .stop_req(stop_req),
    .wake(wake), .parked(parked), .hold_req(hold_req),
    .in_wait(in_wait), .in_stop(in_stop)
  );

  clkgen_divider #(.MID_DIV(MID_DIV), .HIGH_DIV(HIGH_DIV)) u_div (
    .clk(clk_main), .rst_n(rst_int), .req_mode(speed_decode(speed_sel)),
    .sub_rise(sub_rise), .hold_req(hold_req), .sys_clk(sys_clk),
    .parked(parked), .act_mode(act_mode)
  );

  clkgen_osc_ctl u_osc (
    .clk(clk_main), .rst_n(rst_int), .main_off(main_osc_off), .sub_on(sub_osc_on),
    .act_low(act_mode == SPD_LOW), .in_wait(in_wait), .in_stop(in_stop),
    .main_en(main_osc_en), .sub_en(sub_osc_en)
  );

  assign sub_osc_hiz = ~sub_osc_en;
endmodule

// File: rtl/sysclk_gen_chk.sv
module sysclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_clk,
  input logic       main_osc_en,
  input logic       sub_osc_en,
  input logic [1:0] act_mode,
  input logic       in_wait,
  input logic       in_stop
);
  assert_halt_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait || in_stop) |-> sys_clk);

  assert_wait_osc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && $past(in_wait)) |-> ($stable(main_osc_en) && $stable(sub_osc_en)));

  assert_stop_osc_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && $past(in_stop)) |-> (!main_osc_en && !sub_osc_en));

  assert_switch_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode != $past(act_mode)) |-> (sys_clk && $past(sys_clk)));

  assert_main_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_osc_en && !in_stop && !$past(in_stop)) |-> ($past(act_mode) == 2'b10));
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
  .clk(clk_main), .rst_n(rst_n), .sys_clk(sys_clk), .main_osc_en(main_osc_en),
  .sub_osc_en(sub_osc_en), .act_mode(act_mode), .in_wait(in_wait), .in_stop(in_stop)
);

// File: tb/sim_sysclk_gen.sv
`timescale 1ns/1ps
module sim_sysclk_gen;
  localparam int N_IRQ    = 4;
  localparam int SUB_HALF = 5;
  localparam int LOW_PER  = 4 * SUB_HALF;
  localparam int NVEC     = 6;
  localparam logic [1:0] VEC_SEL [NVEC] = '{2'b01, 2'b00, 2'b10, 2'b11, 2'b00, 2'b10};
  localparam int         VEC_PER [NVEC] = '{8, 2, LOW_PER, 8, 2, LOW_PER};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_clk = 1'b0;
  int   sub_cnt = 0;
  logic [1:0] speed_sel = 2'b01;
  logic main_osc_off = 1'b0, sub_osc_on = 1'b0, wait_req = 1'b0, stop_req = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic sys_clk, main_osc_en, sub_osc_en, sub_osc_hiz;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (sub_cnt == SUB_HALF - 1) begin
      sub_cnt <= 0;
      sub_clk <= ~sub_clk;
    end else begin
      sub_cnt <= sub_cnt + 1;
    end
  end

  sysclk_gen #(.N_IRQ(N_IRQ)) u0 (
    .clk_main(clk), .rst_n(rst_n), .sub_osc_in(sub_clk), .speed_sel(speed_sel),
    .main_osc_off(main_osc_off), .sub_osc_on(sub_osc_on), .wait_req(wait_req),
    .stop_req(stop_req), .irq_req(irq_req), .irq_en(irq_en), .sys_clk(sys_clk),
    .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en), .sub_osc_hiz(sub_osc_hiz)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(output bit ok);
    bit p;
    ok = 1'b0;
    p  = sys_clk;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!p && sys_clk) begin
        ok = 1'b1;
        return;
      end
      p = sys_clk;
    end
  endtask

  task automatic measure_period(output int per);
    bit ok;
    bit p;
    per = -1;
    wait_rise(ok);
    if (!ok) return;
    p = 1'b1;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (!p && sys_clk) begin
        per = k;
        return;
      end
      p = sys_clk;
    end
  endtask

  task automatic measure_high(output int len);
    bit ok;
    len = -1;
    wait_rise(ok);
    if (!ok) return;
    len = 1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!sys_clk) return;
      len++;
    end
  endtask

  task automatic wait_low();
    for (int k = 0; k < 400; k++) begin
      if (!sys_clk) return;
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(input logic [1:0] s);
    if (s == 2'b00) return "R3";
    if (s == 2'b10) return "R4";
    return "R2";
  endfunction

  initial begin
    int per, len, lows;
    logic em, es;
    cycles(5);
    // R1 reset state
    chk("R1", sys_clk, 1);
    chk("R1", main_osc_en, 1);
    chk("R1", sub_osc_en, 0);
    chk("R1", sub_osc_hiz, 1);
    rst_n = 1'b1;
    len = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      len++;
      if (!sys_clk) break;
    end
    chk("R1", len, 6);
    measure_period(per);
    chk("R2", per, 8);

    // R7 sub oscillator enable and pin control
    sub_osc_on = 1'b1;
    cycles(3);
    chk("R7", sub_osc_en, 1);
    chk("R7", sub_osc_hiz, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      speed_sel = VEC_SEL[v];
      cycles(80);
      measure_period(per);
      chk(tag_of(VEC_SEL[v]), per, VEC_PER[v]);
      measure_high(len);
      chk(tag_of(VEC_SEL[v]), len, VEC_PER[v] / 2);
    end

    // R5 ratio changes stretch one high phase
    speed_sel = 2'b01;
    cycles(80);
    wait_low();
    speed_sel = 2'b00;
    measure_high(len);
    chk("R5", len, 5);
    cycles(20);
    wait_low();
    speed_sel = 2'b01;
    measure_high(len);
    chk("R5", len, 5);
    cycles(40);

    // R6 main oscillator off only in low-speed
    main_osc_off = 1'b1;
    cycles(20);
    chk("R6", main_osc_en, 1);
    speed_sel = 2'b10;
    cycles(80);
    chk("R6", main_osc_en, 0);
    main_osc_off = 1'b0;
    cycles(5);
    chk("R6", main_osc_en, 1);
    speed_sel = 2'b01;
    cycles(80);

    // R8 wait, R10 masked request
    em = main_osc_en;
    es = sub_osc_en;
    wait_req = 1'b1;
    cycles(1);
    wait_req = 1'b0;
    cycles(30);
    chk("R8", sys_clk, 1);
    irq_req = 4'b0100;
    lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!sys_clk) lows++;
    end
    chk("R10", lows, 0);
    chk("R8", main_osc_en, em);
    chk("R8", sub_osc_en, es);
    // R9 enabled request wakes
    irq_en = 4'b0100;
    cycles(2);
    irq_req = '0;
    irq_en  = '0;
    measure_period(per);
    chk("R9", per, 8);

    // R11 stop
    stop_req = 1'b1;
    cycles(1);
    stop_req = 1'b0;
    cycles(30);
    chk("R11", sys_clk, 1);
    chk("R11", main_osc_en, 0);
    chk("R11", sub_osc_en, 0);
    chk("R11", sub_osc_hiz, 1);
    irq_req = 4'b0001;
    irq_en  = 4'b0001;
    cycles(5);
    irq_req = '0;
    irq_en  = '0;
    chk("R11", main_osc_en, 1);
    chk("R11", sub_osc_en, 1);
    measure_period(per);
    chk("R11", per, 8);

    // R12 simultaneous strobes
    stop_req = 1'b1;
    wait_req = 1'b1;
    cycles(1);
    stop_req = 1'b0;
    wait_req = 1'b0;
    cycles(30);
    chk("R12", main_osc_en, 0);
    chk("R12", sub_osc_en, 0);

    // R13 reset during stop
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(10);
    chk("R13", main_osc_en, 1);
    measure_period(per);
    chk("R13", per, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule